// File: doc/BRIEF.md
# Pipelined Split-Operand Multiplier

This block multiplies two unsigned WIDTH-bit operands (16 by default) and returns the full 2*WIDTH-bit product. Each operand is cut into an upper and a lower half. Four half-width partial products are formed from the half pairs: lower times lower, upper times upper, and the two crossed pairs. Each half-width multiplier is built by applying the same split again, until the operands are LEAF_WIDTH bits wide (4 by default). At that width a leaf unit forms the exact product with a log-domain method. The leaf takes the leading-one positions of both operands, builds a Mitchell estimate from them, then strips those leading ones and repeats on the remainders. With LEAF_WIDTH passes the leaf reaches the exact result.

The partial products are merged in a fixed pipeline. The two crossed products are summed first. That sum, moved up by half a width, then takes the low product. The high product is then added into the upper half of the result. A last stage joins the upper and lower halves into the aligned product. An operand pair is captured on every clock where `in_valid` is high. The product leaves with `out_valid` seven clocks later. Operands may arrive on consecutive clocks or with gaps of any length.

Top module: `split_mult_pipe`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid` clears and `product` becomes zero. Operand pairs in flight at that time never reach the output.
- R2: For every accepted pair, `product` equals a*b as an unsigned 2*WIDTH-bit value.
- R3: The edge that samples a pair with `in_valid` high counts as the first edge. Its product and `out_valid` appear after the seventh rising edge.
- R4: A new operand pair can be accepted on every clock. N pairs on consecutive clocks give N valid results on consecutive clocks.
- R5: Clocks where `in_valid` is low create no result, whatever `a` and `b` carry. The number of results equals the number of accepted pairs, and the gaps in the input reappear in the output.
- R6: Operands below 2^LEAF_WIDTH (here under 16) give exact products. This is the case the iterative leaf unit handles alone.
- R7: The sum of the two crossed products keeps its carry. An example is a = b = 0xFFFF, where both crossed products are 0xFE01 and their sum needs 17 bits.
- R8: The lower half of an operand is bits [WIDTH/2-1:0] and the upper half is bits [WIDTH-1:WIDTH/2]. Operands whose set bits lie in only one half give correct products. Examples are 0xFF00*0xFF00 = 0xFE010000 and 0x00FF*0x0100 = 0xFF00.
- R9: While `out_valid` is low, `product` holds the last value delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `a` and `b` carry a pair to multiply |
| a | input | WIDTH | First unsigned operand |
| b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | High for one clock per delivered product |
| product | output | 2*WIDTH | Unsigned product of the pair |

## Verification
Assertions check four things on every cycle once the pipeline has filled. Each `out_valid` must match the strobe seven clocks earlier. Each delivered product must equal the product of the operands sampled seven clocks earlier. The output must hold while no result is delivered. The crossed-product sum must never lose its carry. Each leaf also checks its own result against exact multiplication whenever its inputs are known. Only the bench scenarios can show that a mid-stream reset really discards the operations in flight. They also show that a long burst comes out without gaps, and that a bubble pattern reappears with exactly as many results as inputs.

// File: rtl/smul_pkg.sv
// Package: shared constants and helpers for the split multiplier.
// Assumes operands handed to lead_one fit in 32 bits.
package smul_pkg;

    // Register stages from the operand capture to the output.
    localparam int LATENCY = 7;

    // Position of the most significant set bit; 0 for a zero input.
    function automatic int lead_one(input logic [31:0] v);
        int pos;
        pos = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) pos = i;
        end
        return pos;
    endfunction

endpackage

// File: rtl/smul_leaf.sv
// Module: smul_leaf
// Exact W x W unsigned product from iterated log-domain estimates.
// Each pass finds the leading ones k1, k2 of the remainders and adds
// 2^(k1+k2) + r1*2^k2 + r2*2^k1. It then drops both leading ones, so
// the error left over is r1*r2. After at most W passes that error is zero.
// Assumes W <= 32. Purely combinational.
module smul_leaf
    import smul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    // Iterated estimate-and-correct passes over the operand remainders.
    always_comb begin : iterate
        logic [W-1:0]  n1, n2, r1, r2;
        logic [PW-1:0] acc;
        int            k1, k2;
        n1  = x;
        n2  = y;
        r1  = '0;
        r2  = '0;
        k1  = 0;
        k2  = 0;
        acc = '0;
        for (int it = 0; it < W; it++) begin
            if ((n1 != '0) && (n2 != '0)) begin
                k1  = lead_one(32'(n1));
                k2  = lead_one(32'(n2));
                r1  = n1 & ~(W'(1) << k1);
                r2  = n2 & ~(W'(1) << k2);
                acc = acc + (PW'(1) << (k1 + k2))
                          + (PW'(r1) << k2)
                          + (PW'(r2) << k1);
                n1  = r1;
                n2  = r2;
            end
        end
        p = acc;
        // R6: the iterated estimate must land on the exact product
        if (!$isunknown({x, y})) begin
            a_r6_leaf_exact: assert (acc == PW'(x) * PW'(y));
        end
    end

endmodule

// File: rtl/smul_tree.sv
// Module: smul_tree
// Combinational W x W unsigned multiplier. It splits both operands into
// halves and recurses until W <= LEAF_W, where an iterative leaf takes over.
// Assumes W = LEAF_W * 2^k.
module smul_tree #(
    parameter int W      = 8,
    parameter int LEAF_W = 4
) (
    input  logic [W-1:0]   x,
    input  logic [W-1:0]   y,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    generate
        if (W <= LEAF_W) begin : g_leaf
            smul_leaf #(.W(W)) u_leaf (
                .x(x),
                .y(y),
                .p(p)
            );
        end else begin : g_split
            localparam int HW = W / 2;
            logic [W-1:0] q_ll, q_hh, q_hl, q_lh;

            smul_tree #(.W(HW), .LEAF_W(LEAF_W)) u_ll (
                .x(x[HW-1:0]), .y(y[HW-1:0]), .p(q_ll));
            smul_tree #(.W(HW), .LEAF_W(LEAF_W)) u_hh (
                .x(x[W-1:HW]), .y(y[W-1:HW]), .p(q_hh));
            smul_tree #(.W(HW), .LEAF_W(LEAF_W)) u_hl (
                .x(x[W-1:HW]), .y(y[HW-1:0]), .p(q_hl));
            smul_tree #(.W(HW), .LEAF_W(LEAF_W)) u_lh (
                .x(x[HW-1:0]), .y(y[W-1:HW]), .p(q_lh));

            // Merge the four partials: high|low concatenated plus mid shifted by HW.
            always_comb begin
                p = {q_hh, q_ll} + ((PW'(q_hl) + PW'(q_lh)) << HW);
            end
        end
    endgenerate

endmodule

// File: rtl/smul_merge_pipe.sv
// Module: smul_merge_pipe
// Four-stage merge of the half-width partial products. Stage 1 sums the
// two crossed products into W+1 bits. Stage 2 adds low under that sum,
// shifted up by W/2. Stage 3 adds high into the upper half. Stage 4
// aligns the two halves into the product.
// Assumes W is even and at least 4. Data registers load only on valid.
module smul_merge_pipe #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [W-1:0]   low,
    input  logic [W-1:0]   high,
    input  logic [W-1:0]   mid1,
    input  logic [W-1:0]   mid2,
    output logic           out_valid,
    output logic [2*W-1:0] product
);
    localparam int H   = W / 2;
    localparam int MW  = W + 1;
    localparam int LMW = W + H + 2;

    logic           v1, v2, v3, v4;
    logic [MW-1:0]  mid_q;
    logic [W-1:0]   low1, high1, high2, hi_q, lo_q;
    logic [LMW-1:0] lowmid_q;
    logic [2*W-1:0] prod_q;

    // Adder 1: crossed products summed with the carry kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1    <= 1'b0;
            mid_q <= '0;
            low1  <= '0;
            high1 <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) begin
                mid_q <= MW'(mid1) + MW'(mid2);
                low1  <= low;
                high1 <= high;
            end
        end
    end

    // Adder 2: low product joined under the shifted mid sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2       <= 1'b0;
            lowmid_q <= '0;
            high2    <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                lowmid_q <= (LMW'(mid_q) << H) + LMW'(low1);
                high2    <= high1;
            end
        end
    end

    // Adder 3: high product added into the upper half only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3   <= 1'b0;
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            v3 <= v2;
            if (v2) begin
                hi_q <= high2 + W'(lowmid_q[LMW-1:W]);
                lo_q <= lowmid_q[W-1:0];
            end
        end
    end

    // Alignment: upper and lower halves placed into the product word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v4     <= 1'b0;
            prod_q <= '0;
        end else begin
            v4 <= v3;
            if (v3) prod_q <= {hi_q, lo_q};
        end
    end

    assign out_valid = v4;
    assign product   = prod_q;

    // R7: the mid sum never drops below an addend, so no carry is lost
    a_r7_mid_carry: assert property (@(posedge clk) disable iff (!rst_n)
        v1 |-> (mid_q >= MW'($past(mid1))) && (mid_q >= MW'($past(mid2))));

endmodule

// File: rtl/split_mult_pipe.sv
// Module: split_mult_pipe (top)
// WIDTH x WIDTH unsigned multiplier with a fixed seven-stage pipeline.
// The stages are operand capture and split, four half-width partial
// products, three adders, alignment and the output register.
// Accepts one pair per clock. Assumes WIDTH = LEAF_WIDTH * 2^k, k >= 1.
module split_mult_pipe
    import smul_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int LEAF_WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] product
);
    localparam int H  = WIDTH / 2;
    localparam int PW = 2 * WIDTH;

    logic             v_dec, v_sub, m_valid;
    logic [WIDTH-1:0] a_q, b_q;
    logic [H-1:0]     op_x [4];
    logic [H-1:0]     op_y [4];
    logic [WIDTH-1:0] part_c [4];
    logic [WIDTH-1:0] part_q [4];
    logic [PW-1:0]    m_prod;

    // Stage 1: capture the operand pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_dec <= 1'b0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            v_dec <= in_valid;
            if (in_valid) begin
                a_q <= a;
                b_q <= b;
            end
        end
    end

    // Half selection: 0 low, 1 high, 2 mid1 (aH*bL), 3 mid2 (aL*bH).
    always_comb begin
        op_x[0] = a_q[H-1:0];      op_y[0] = b_q[H-1:0];
        op_x[1] = a_q[WIDTH-1:H];  op_y[1] = b_q[WIDTH-1:H];
        op_x[2] = a_q[WIDTH-1:H];  op_y[2] = b_q[H-1:0];
        op_x[3] = a_q[H-1:0];      op_y[3] = b_q[WIDTH-1:H];
    end

    generate
        for (genvar g = 0; g < 4; g++) begin : g_part
            smul_tree #(.W(H), .LEAF_W(LEAF_WIDTH)) u_part (
                .x(op_x[g]),
                .y(op_y[g]),
                .p(part_c[g])
            );
        end
    endgenerate

    // Stage 2: register the four partial products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_sub <= 1'b0;
            for (int i = 0; i < 4; i++) part_q[i] <= '0;
        end else begin
            v_sub <= v_dec;
            if (v_dec) begin
                for (int i = 0; i < 4; i++) part_q[i] <= part_c[i];
            end
        end
    end

    smul_merge_pipe #(.W(WIDTH)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (v_sub),
        .low      (part_q[0]),
        .high     (part_q[1]),
        .mid1     (part_q[2]),
        .mid2     (part_q[3]),
        .out_valid(m_valid),
        .product  (m_prod)
    );

    // Stage 7: output register, holding its value between results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= m_valid;
            if (m_valid) product <= m_prod;
        end
    end

    // Edges since reset, saturating at the latency; qualifies $past below.
    logic [3:0] settle;
    always_ff @(posedge clk) begin
        if (!rst_n)                     settle <= '0;
        else if (settle != 4'(LATENCY)) settle <= settle + 4'd1;
    end

    // R3: result strobe mirrors the input strobe seven clocks back
    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (settle == 4'(LATENCY)) |-> (out_valid == $past(in_valid, 7)));

    // R2: delivered product equals the operands seen seven clocks back
    a_r2_product: assert property (@(posedge clk) disable iff (!rst_n)
        ((settle == 4'(LATENCY)) && out_valid)
            |-> (product == PW'($past(a, 7)) * PW'($past(b, 7))));

    // R9: no result delivered, no change on the product
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(product));

endmodule

// File: tb/split_mult_pipe_tb_top.sv
`timescale 1ns/1ps
module split_mult_pipe_tb_top;
    localparam int W = 16;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           in_valid;
    logic [W-1:0]   a, b;
    logic           out_valid;
    logic [2*W-1:0] product;

    always #2.5 clk = ~clk;

    split_mult_pipe #(.WIDTH(W), .LEAF_WIDTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a(a), .b(b), .out_valid(out_valid), .product(product)
    );

    // {tag, a, b, expected}
    localparam logic [71:0] VEC [12] = '{
        {8'd2, 16'h0000, 16'hFFFF, 32'h00000000},  // R2 zero
        {8'd2, 16'hFFFF, 16'h0001, 32'h0000FFFF},  // R2 identity
        {8'd2, 16'h1234, 16'h5678, 32'h06260060},  // R2 mixed
        {8'd2, 16'h8000, 16'h8000, 32'h40000000},  // R2 single bits
        {8'd2, 16'hF0F0, 16'h0F0F, 32'h0E2C2E10},  // R2 patterns
        {8'd7, 16'hFFFF, 16'hFFFF, 32'hFFFE0001},  // R7 mid carry
        {8'd6, 16'h0007, 16'h0009, 32'h0000003F},  // R6 leaf only
        {8'd6, 16'h000F, 16'h000F, 32'h000000E1},  // R6 leaf max
        {8'd8, 16'hFF00, 16'hFF00, 32'hFE010000},  // R8 upper halves
        {8'd8, 16'h00FF, 16'h0100, 32'h0000FF00},  // R8 crossed halves
        {8'd8, 16'h0010, 16'h1000, 32'h00010000},  // R8 single bits
        {8'd6, 16'h00FF, 16'h00FF, 32'h0000FE01}   // R6 lower halves
    };

    int          total = 0, bad = 0;
    int          run = 0, max_run = 0, n_out = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [31:0] last_prod = '0;
    logic [31:0] e_m;
    string       t_m;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // Scoreboard: every delivered result must match the oldest pending pair.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (out_valid) begin
                n_out++;
                run++;
                if (run > max_run) max_run = run;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected result", product, 32'h0);
                end else begin
                    e_m = exp_q.pop_front();
                    t_m = tag_q.pop_front();
                    check(product == e_m, t_m, "product", product, e_m);
                    last_prod = product;
                end
            end else begin
                run = 0;
            end
        end
    end

    task automatic drive(input bit v, input logic [W-1:0] x,
                         input logic [W-1:0] y, input string tag);
        @(negedge clk);
        in_valid = v;
        a        = x;
        b        = y;
        if (v) begin
            exp_q.push_back(32'(x) * 32'(y));
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, W'($urandom), W'($urandom), "");
    endtask

    initial begin : main
        int lat, n0;
        rst_n = 1'b0; in_valid = 1'b0; a = '0; b = '0;
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", 32'(out_valid), 32'h0);
        check(product == '0, "R1", "product in reset", product, 32'h0);
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1", "valid after reset", 32'(out_valid), 32'h0);

        // R3: count edges from the sampling edge to the result
        drive(1'b1, 16'h0003, 16'h0005, "R3");
        lat = 0;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 1) in_valid = 1'b0;
            if (out_valid && lat == 0) lat = k;
        end
        check(lat == 7, "R3", "latency", 32'(lat), 32'd7);

        // Vector table streamed back to back (R2, R4, R6, R7, R8)
        max_run = 0;
        foreach (VEC[i]) begin
            drive(1'b1, VEC[i][63:48], VEC[i][47:32],
                  $sformatf("R%0d", VEC[i][71:64]));
            check(32'(VEC[i][63:48]) * 32'(VEC[i][47:32]) == VEC[i][31:0],
                  "R2", "table entry", 32'(VEC[i][63:48]) * 32'(VEC[i][47:32]),
                  VEC[i][31:0]);
        end
        idle(10);
        check(max_run == 12, "R4", "burst run length", 32'(max_run), 32'd12);

        // R5: bubbles with random operands while in_valid is low
        n0 = n_out;
        for (int i = 0; i < 24; i++)
            drive((i % 3) == 0, W'($urandom), W'($urandom), "R5");
        idle(10);
        check(n_out - n0 == 8, "R5", "result count", 32'(n_out - n0), 32'd8);

        // R9: output holds during idle cycles
        for (int i = 0; i < 6; i++) begin
            idle(1);
            check(product == last_prod && !out_valid, "R9", "hold",
                  product, last_prod);
        end

        // R2: random traffic
        for (int i = 0; i < 400; i++)
            drive(($urandom % 4) != 0, W'($urandom), W'($urandom), "R2");
        idle(10);
        check(exp_q.size() == 0, "R2", "pending results", 32'(exp_q.size()), 32'h0);

        // R1: reset with pairs in flight discards them
        for (int i = 0; i < 4; i++) drive(1'b1, 16'hABCD, 16'h1357, "R1");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        exp_q.delete(); tag_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(product == '0, "R1", "product cleared", product, 32'h0);
        for (int i = 0; i < 10; i++) begin
            idle(1);
            check(out_valid == 1'b0, "R1", "flushed", 32'(out_valid), 32'h0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule